// File: doc/BRIEF.md
# Banked Register and Stack Address Unit

This block forms the internal data-memory byte address for a small 8-bit controller on every cycle. Given an operation class from the instruction decoder, it turns a register name R0..R7 into a byte address in one of four eight-byte banks, passes a direct byte address through untouched, resolves an indirect access through the R0 or R1 value of the active bank, and splits a bit address into a byte address and a bit position. It also owns the stack pointer and produces the stack slot addresses for single-byte push and pop and for two-byte call and return.

The address outputs are purely combinational from the inputs and the current stack pointer. The stack pointer itself updates on the rising clock edge after a stack operation. For call and return, both byte addresses are offered in the same cycle on two outputs, so the surrounding datapath can move the 16-bit return address in one step. The RAM array, the instruction decoder and the contents of R0/R1 and the special registers live outside the block.

Top module: `regbank_addr_unit`

## Requirements
- R1: After a synchronous reset the stack pointer output reads 07h.
- R2: For op code 1 (register), the address is bank_sel*8 + reg_idx, so banks 0..3 cover 00h-07h, 08h-0Fh, 10h-17h and 18h-1Fh; addr2_o and bit_pos_o read 0.
- R3: For op code 2 (direct), the address equals addr_in for all 256 values, including values below 20h that name a register of an inactive bank.
- R4: For op code 3 (indirect), the address is r0_val when reg_idx bit 0 is 0 and r1_val when it is 1.
- R5: For op code 4 (bit) with addr_in below 80h, the address is 20h + (addr_in >> 3) and bit_pos_o is addr_in[2:0].
- R6: For op code 4 with addr_in of 80h or more, the address is addr_in with its low three bits cleared and bit_pos_o is addr_in[2:0], so bit 0 of a bit-addressable special register shares the register's address.
- R7: For op code 5 (push), the address is SP+1 and the stack pointer becomes SP+1 at the next clock edge.
- R8: For op code 6 (pop), the address is SP and the stack pointer becomes SP-1 at the next clock edge.
- R9: For op code 7 (call), addr_o (low return byte) is SP+1, addr2_o (high return byte) is SP+2, and the stack pointer becomes SP+2.
- R10: For op code 8 (return), addr_o (high return byte) is SP, addr2_o (low return byte) is SP-1, and the stack pointer becomes SP-2.
- R11: All stack pointer and stack address arithmetic wraps modulo 256 with no error indication.
- R12: For op code 0 and codes 9..15, all address outputs and bit_pos_o read 0 and the stack pointer does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation class code (0..8 defined) |
| bank_sel | input | 2 | Register bank select from status word |
| reg_idx | input | 3 | Register index R0..R7; bit 0 picks R0/R1 for indirect |
| addr_in | input | 8 | Direct byte address or bit address |
| r0_val | input | 8 | Contents of R0 of the active bank |
| r1_val | input | 8 | Contents of R1 of the active bank |
| addr_o | output | 8 | Primary byte address |
| addr2_o | output | 8 | Second byte address for call/return |
| bit_pos_o | output | 3 | Bit position within the addressed byte |
| sp_o | output | 8 | Current stack pointer |

## Verification
On every cycle the assertions check the stack pointer's reset value, its exact step for each stack operation (+1, -1, +2, -2, or hold), that register accesses stay in the lowest 32 bytes, and that low bit addresses land in the 20h-2Fh window. The exact address values across all banks, registers, direct and bit addresses, the R0/R1 choice, the order of the two return-address bytes and the modulo-256 wrap over a full lap of pushes are shown only by the bench's sweeps against arithmetic expectations.

// File: rtl/addr_pkg.sv
package addr_pkg;

    localparam int AW    = 8;
    localparam int POS_W = 3;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_REG  = 4'd1,
        OP_DIR  = 4'd2,
        OP_IND  = 4'd3,
        OP_BIT  = 4'd4,
        OP_PUSH = 4'd5,
        OP_POP  = 4'd6,
        OP_CALL = 4'd7,
        OP_RET  = 4'd8
    } op_t;

    typedef struct packed {
        logic [AW-1:0]    first;
        logic [AW-1:0]    second;
        logic [POS_W-1:0] pos;
    } addr_res_t;

    function automatic op_t decode_op(input logic [3:0] raw);
        if (raw > 4'd8) return OP_NOP;
        return op_t'(raw);
    endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map
    import addr_pkg::*;
#(
    parameter int BANK_BITS = 2,
    parameter int IDX_BITS  = 3
) (
    input  logic [BANK_BITS-1:0] bank,
    input  logic [IDX_BITS-1:0]  idx,
    input  logic [AW-1:0]        r0,
    input  logic [AW-1:0]        r1,
    output logic [AW-1:0]        reg_addr,
    output logic [AW-1:0]        ind_addr
);
    localparam int PAD = AW - BANK_BITS - IDX_BITS;

    generate
        if (PAD > 0) begin : g_pad
            assign reg_addr = {{PAD{1'b0}}, bank, idx};
        end else begin : g_nopad
            assign reg_addr = AW'({bank, idx});
        end
    endgenerate

    // Only the lowest index bit chooses the pointer register.
    assign ind_addr = idx[0] ? r1 : r0;
endmodule

// File: rtl/bit_map.sv
module bit_map
    import addr_pkg::*;
#(
    parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
    input  logic [AW-1:0]    bit_addr,
    output logic [AW-1:0]    byte_addr,
    output logic [POS_W-1:0] pos
);
    assign pos = bit_addr[POS_W-1:0];

    always_comb begin
        if (bit_addr[AW-1]) begin
            byte_addr = {bit_addr[AW-1:POS_W], {POS_W{1'b0}}};
        end else begin
            byte_addr = BIT_BASE + (bit_addr >> POS_W);
        end
    end
endmodule

// File: rtl/stack_ptr.sv
module stack_ptr
    import addr_pkg::*;
#(
    parameter logic [AW-1:0] SP_RST = 8'h07
) (
    input  logic          clk,
    input  logic          rst,
    input  op_t           op,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] sp_p1,
    output logic [AW-1:0] sp_p2,
    output logic [AW-1:0] sp_m1
);
    logic [AW-1:0] sp_q, sp_n;

    assign sp    = sp_q;
    assign sp_p1 = sp_q + AW'(1);
    assign sp_p2 = sp_q + AW'(2);
    assign sp_m1 = sp_q - AW'(1);

    always_comb begin
        unique case (op)
            OP_PUSH: sp_n = sp_p1;
            OP_POP:  sp_n = sp_m1;
            OP_CALL: sp_n = sp_p2;
            OP_RET:  sp_n = sp_q - AW'(2);
            default: sp_n = sp_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sp_q <= SP_RST;
        else     sp_q <= sp_n;
    end

    a_r1_sp_reset: assert property (@(posedge clk) rst |=> sp_q == SP_RST);
    a_r7_push_step: assert property (@(posedge clk) disable iff (rst)
        op == OP_PUSH |=> sp_q == $past(sp_q) + AW'(1));
    a_r8_pop_step: assert property (@(posedge clk) disable iff (rst)
        op == OP_POP |=> sp_q == $past(sp_q) - AW'(1));
    a_r9_call_step: assert property (@(posedge clk) disable iff (rst)
        op == OP_CALL |=> sp_q == $past(sp_q) + AW'(2));
    a_r10_ret_step: assert property (@(posedge clk) disable iff (rst)
        op == OP_RET |=> sp_q == $past(sp_q) - AW'(2));
    a_r12_sp_hold: assert property (@(posedge clk) disable iff (rst)
        !(op inside {OP_PUSH, OP_POP, OP_CALL, OP_RET}) |=> $stable(sp_q));
endmodule

// File: rtl/regbank_addr_unit.sv
module regbank_addr_unit
    import addr_pkg::*;
#(
    parameter int              BANK_BITS = 2,
    parameter int              IDX_BITS  = 3,
    parameter logic [AW-1:0]   BIT_BASE  = 8'h20,
    parameter logic [AW-1:0]   SP_RST    = 8'h07
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [3:0]           op,
    input  logic [BANK_BITS-1:0] bank_sel,
    input  logic [IDX_BITS-1:0]  reg_idx,
    input  logic [AW-1:0]        addr_in,
    input  logic [AW-1:0]        r0_val,
    input  logic [AW-1:0]        r1_val,
    output logic [AW-1:0]        addr_o,
    output logic [AW-1:0]        addr2_o,
    output logic [POS_W-1:0]     bit_pos_o,
    output logic [AW-1:0]        sp_o
);
    op_t           op_d;
    logic [AW-1:0] reg_addr, ind_addr, bit_byte;
    logic [POS_W-1:0] bit_pos;
    logic [AW-1:0] sp, sp_p1, sp_p2, sp_m1;
    addr_res_t     res;

    assign op_d = decode_op(op);

    bank_map #(.BANK_BITS(BANK_BITS), .IDX_BITS(IDX_BITS)) u_bank (
        .bank(bank_sel), .idx(reg_idx), .r0(r0_val), .r1(r1_val),
        .reg_addr(reg_addr), .ind_addr(ind_addr)
    );

    bit_map #(.BIT_BASE(BIT_BASE)) u_bit (
        .bit_addr(addr_in), .byte_addr(bit_byte), .pos(bit_pos)
    );

    stack_ptr #(.SP_RST(SP_RST)) u_sp (
        .clk(clk), .rst(rst), .op(op_d), .sp(sp),
        .sp_p1(sp_p1), .sp_p2(sp_p2), .sp_m1(sp_m1)
    );

    always_comb begin
        res = '0;
        unique case (op_d)
            OP_REG:  res.first = reg_addr;
            OP_DIR:  res.first = addr_in;
            OP_IND:  res.first = ind_addr;
            OP_BIT:  begin res.first = bit_byte; res.pos = bit_pos; end
            OP_PUSH: res.first = sp_p1;
            OP_POP:  res.first = sp;
            OP_CALL: begin res.first = sp_p1; res.second = sp_p2; end
            OP_RET:  begin res.first = sp;    res.second = sp_m1; end
            default: res = '0;
        endcase
    end

    assign addr_o    = res.first;
    assign addr2_o   = res.second;
    assign bit_pos_o = res.pos;
    assign sp_o      = sp;

    a_r2_reg_low32: assert property (@(posedge clk) disable iff (rst)
        op_d == OP_REG |-> addr_o < 8'h20 && bit_pos_o == '0);
    a_r5_bit_window: assert property (@(posedge clk) disable iff (rst)
        (op_d == OP_BIT && !addr_in[AW-1]) |-> (addr_o >= 8'h20 && addr_o <= 8'h2F));
    a_r9_call_pair: assert property (@(posedge clk) disable iff (rst)
        op_d == OP_CALL |-> addr2_o == addr_o + AW'(1));
endmodule

// File: tb/sim_regbank_addr_unit.sv
module sim_regbank_addr_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] op;
    logic [1:0] bank_sel;
    logic [2:0] reg_idx;
    logic [7:0] addr_in, r0_val, r1_val;
    logic [7:0] addr_o, addr2_o, sp_o;
    logic [2:0] bit_pos_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_sp;

    always #2 clk = ~clk;

    regbank_addr_unit u0 (
        .clk(clk), .rst(rst), .op(op), .bank_sel(bank_sel), .reg_idx(reg_idx),
        .addr_in(addr_in), .r0_val(r0_val), .r1_val(r1_val),
        .addr_o(addr_o), .addr2_o(addr2_o), .bit_pos_o(bit_pos_o), .sp_o(sp_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Apply at a negedge, check combinational outputs, clock, check SP.
    task automatic step(input logic [3:0] o, input logic [7:0] a,
                        input logic [7:0] e1, input logic [7:0] e2,
                        input logic [7:0] epos, input logic [7:0] next_sp,
                        input string req);
        op = o; addr_in = a;
        #1;
        chk(req, addr_o, e1);
        chk(req, addr2_o, e2);
        chk(req, {5'd0, bit_pos_o}, epos);
        @(posedge clk);
        exp_sp = next_sp;
        @(negedge clk);
        chk(req, sp_o, exp_sp);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; op = 4'd0; bank_sel = 2'd0; reg_idx = 3'd0;
        addr_in = 8'h00; r0_val = 8'h00; r1_val = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_sp = 8'h07;
        chk("R1", sp_o, 8'h07);

        // R2: every bank and register
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 8; i++) begin
                bank_sel = 2'(b); reg_idx = 3'(i);
                step(4'd1, 8'hFF, 8'(b * 8 + i), 8'h00, 8'h00, exp_sp, "R2");
            end
        end

        // R3: all direct addresses, under a non-zero bank
        bank_sel = 2'd2;
        for (int a = 0; a < 256; a++)
            step(4'd2, 8'(a), 8'(a), 8'h00, 8'h00, exp_sp, "R3");

        // R4: indirect pointer choice
        for (int i = 0; i < 8; i++) begin
            reg_idx = 3'(i);
            r0_val = 8'(8'h30 + i); r1_val = 8'(8'hC5 - i);
            step(4'd3, 8'h00, (i % 2 == 1) ? 8'(8'hC5 - i) : 8'(8'h30 + i),
                 8'h00, 8'h00, exp_sp, "R4");
        end

        // R5 / R6: all bit addresses
        for (int a = 0; a < 256; a++) begin
            if (a < 128)
                step(4'd4, 8'(a), 8'(32 + a / 8), 8'h00, 8'(a % 8), exp_sp, "R5");
            else
                step(4'd4, 8'(a), 8'(a - a % 8), 8'h00, 8'(a % 8), exp_sp, "R6");
        end

        // R12: undefined and idle codes
        for (int c = 9; c < 16; c++)
            step(4'(c), 8'h9B, 8'h00, 8'h00, 8'h00, exp_sp, "R12");
        step(4'd0, 8'h9B, 8'h00, 8'h00, 8'h00, exp_sp, "R12");

        // R7 / R11: a full lap of pushes plus a few, wrapping past FFh
        for (int k = 0; k < 260; k++)
            step(4'd5, 8'h00, 8'(exp_sp + 1), 8'h00, 8'h00, 8'(exp_sp + 1), "R7_R11");
        chk("R11", sp_o, 8'h0B);

        // R8: pops
        for (int k = 0; k < 5; k++)
            step(4'd6, 8'h00, exp_sp, 8'h00, 8'h00, 8'(exp_sp - 1), "R8");
        chk("R8", sp_o, 8'h06);

        // R9 / R10: call then return
        step(4'd7, 8'h00, 8'h07, 8'h08, 8'h00, 8'h08, "R9");
        step(4'd7, 8'h00, 8'h09, 8'h0A, 8'h00, 8'h0A, "R9");
        step(4'd8, 8'h00, 8'h0A, 8'h09, 8'h00, 8'h08, "R10");
        step(4'd8, 8'h00, 8'h08, 8'h07, 8'h00, 8'h06, "R10");

        // R11: wrap below zero and across FFh with two-byte ops
        for (int k = 0; k < 4; k++)
            step(4'd8, 8'h00, exp_sp, 8'(exp_sp - 1), 8'h00, 8'(exp_sp - 2), "R10_R11");
        chk("R11", sp_o, 8'hFE);
        step(4'd7, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, "R9_R11");
        step(4'd6, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, "R8_R11");

        // R1: reset again restores 07h
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", sp_o, 8'h07);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule